// File: doc/BRIEF.md
# Dual-Sided Interrupt Mailbox

This block lets two processors signal each other and exchange data. Both processors see one shared register map through their own simple bus port: an address, a write enable, write data, and read data that follows the address in the same cycle. There are two interrupt banks, one for each direction. Bank 0 delivers events to side 0 and holds its 16 sources in bits 31:16 of its registers. Bank 1 delivers events to side 1 and holds its sources in bits 15:0. Each side gets one level interrupt output.

Each bank has four registers. A generate register sets status bits. A clear register clears status bits when a 1 is written to them (write-one-to-clear). A mask register stops a source from driving the interrupt output. A status register can be read. A masked source still latches its status bit, so software can poll it and clear it later. Either side may write either generate register. A processor can raise an event toward its peer, or re-signal a pending event to itself after masking it. Sixty-four 32-bit message registers at a 4-byte stride carry data. They work independently of the interrupt logic. A self-clearing software-reset bit in a control register returns all mailbox state to its reset values.

Register map, as byte addresses. Word-aligned addresses only; any address with bits 1:0 non-zero is unmapped.

| Address | Register |
|---|---|
| 0x000 | control; bit 0 is the software-reset bit |
| 0x008 | bank 0 generate |
| 0x00C | bank 0 clear |
| 0x010 | bank 0 mask |
| 0x014 | bank 0 status |
| 0x020 | bank 1 generate |
| 0x024 | bank 1 clear |
| 0x028 | bank 1 mask |
| 0x02C | bank 1 status |
| 0x100 + 4*i | message register i, for i from 0 to 63 |

Top module: `ipc_mailbox`

## Requirements
- R1: After the asynchronous reset, every status bit, mask bit and message register is zero, and both interrupt outputs are low.
- R2: A write to bank 0 generate (0x008) sets status bit n+16 for each 1 in data bit n+16. A write to bank 1 generate (0x020) sets status bit n for each 1 in data bit n. The other half of the written data is ignored. The bit is visible in the bank's status register (0x014 or 0x02C) after the write's clock edge. Either port may do this.
- R3: A write to a bank's clear register (0x00C or 0x02C minus 8, i.e. 0x024) clears only the status bits of that bank's half that are written as 1. All other status bits keep their values. Writing 0x0000FFFF to 0x024 empties bank 1.
- R4: irq0_o is high exactly while some bit of bank 0 has its status bit set and its mask bit clear. irq1_o follows the same rule for bank 1. A masked source still sets its status bit.
- R5: The mask registers (0x010 and 0x028) store only their bank's half and read it back. The other half reads zero.
- R6: When a generate write and a clear write hit the same status bit in the same cycle, the bit ends set.
- R7: A word written to message register i from either port is read from address 0x100+4*i by both ports from the next cycle on. A message write does not change any interrupt state.
- R8: Writing 1 to bit 0 of control (0x000) from either port zeroes all status, mask and message state at that clock edge. This overrides every other write in the same cycle. Control always reads zero.
- R9: Reads from unmapped addresses, including non-word-aligned ones, return zero, and writes to them change nothing. Generate and clear registers read zero.
- R10: If both ports write the same message register or the same mask register in one cycle, port 1's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| p0_addr | input | 9 | port 0 byte address |
| p0_we | input | 1 | port 0 write enable |
| p0_wdata | input | 32 | port 0 write data |
| p0_rdata | output | 32 | port 0 read data for p0_addr |
| p1_addr | input | 9 | port 1 byte address |
| p1_we | input | 1 | port 1 write enable |
| p1_wdata | input | 32 | port 1 write data |
| p1_rdata | output | 32 | port 1 read data for p1_addr |
| irq0_o | output | 1 | level interrupt toward side 0 |
| irq1_o | output | 1 | level interrupt toward side 1 |

## Verification
The assertions check these rules on every cycle:
- A generated bit survives a simultaneous clear.
- A clear touches only the bits that were written as 1 and not set in the same cycle.
- A mask write lands with port 1 taking priority.
- A message write lands with port 1 taking priority.
- A software reset empties a bank.

Some behaviour can only be shown by the bench scenarios:
- The register-map decode and field placement.
- That the interrupt outputs follow status and mask together.
- That unmapped and misaligned accesses leave state untouched.
- That a software reset overrides a message write in the same cycle.

The bench shows these with directed cases and with random traffic from both ports compared against a reference model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W = 32;
    localparam int HALF   = DATA_W / 2;

    // word indices (byte address / 4) of the control and interrupt registers
    localparam int W_CTRL  = 0;
    localparam int W_GEN0  = 2;
    localparam int W_CLR0  = 3;
    localparam int W_MASK0 = 4;
    localparam int W_STAT0 = 5;
    localparam int W_GEN1  = 8;
    localparam int W_CLR1  = 9;
    localparam int W_MASK1 = 10;
    localparam int W_STAT1 = 11;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL,
        SEL_GEN0, SEL_CLR0, SEL_MASK0, SEL_STAT0,
        SEL_GEN1, SEL_CLR1, SEL_MASK1, SEL_STAT1,
        SEL_MSG
    } reg_sel_e;

    function automatic reg_sel_e decode_word(int w, int msg_base_w, int n_msg);
        reg_sel_e s;
        case (w)
            W_CTRL:  s = SEL_CTRL;
            W_GEN0:  s = SEL_GEN0;
            W_CLR0:  s = SEL_CLR0;
            W_MASK0: s = SEL_MASK0;
            W_STAT0: s = SEL_STAT0;
            W_GEN1:  s = SEL_GEN1;
            W_CLR1:  s = SEL_CLR1;
            W_MASK1: s = SEL_MASK1;
            W_STAT1: s = SEL_STAT1;
            default: s = (w >= msg_base_w && w < msg_base_w + n_msg) ? SEL_MSG : SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
    parameter int SRC_N = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_rst,
    input  logic [SRC_N-1:0]           set_vec,
    input  logic [SRC_N-1:0]           clr_vec,
    input  logic [1:0]                 mask_we,
    input  logic [1:0][SRC_N-1:0]      mask_d,
    output logic [SRC_N-1:0]           stat_o,
    output logic [SRC_N-1:0]           mask_o,
    output logic                       irq_o
);
    typedef struct packed {
        logic [SRC_N-1:0] stat;
        logic [SRC_N-1:0] mask;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d = '0;
        end else begin
            // a set in the same cycle wins over a clear
            st_d.stat = (st_q.stat & ~clr_vec) | set_vec;
            for (int p = 0; p < 2; p++) begin
                if (mask_we[p]) st_d.mask = mask_d[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.stat & ~st_q.mask);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && (set_vec != '0)) |=> ((st_q.stat & $past(set_vec)) == $past(set_vec)));

    // R3
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((st_q.stat & $past(clr_vec & ~set_vec)) == '0));

    // R3
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> (((st_q.stat ^ $past(st_q.stat)) & ~$past(set_vec | clr_vec)) == '0));

    // R10
    mask_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && mask_we[1]) |=> (st_q.mask == $past(mask_d[1])));

    // R8
    srst_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q == '0 && !irq_o));
endmodule

// File: rtl/mbx_msg_file.sv
module mbx_msg_file #(
    parameter int N_MSG  = 64,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(N_MSG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        soft_rst,
    input  logic [1:0]                  we,
    input  logic [1:0][IDX_W-1:0]       idx,
    input  logic [1:0][DATA_W-1:0]      wd,
    output logic [1:0][DATA_W-1:0]      rd
);
    typedef struct packed {
        logic [N_MSG-1:0][DATA_W-1:0] word;
    } msg_t;

    msg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d = '0;
        end else begin
            // port 1 is applied last, so it wins a same-word collision
            for (int p = 0; p < 2; p++) begin
                if (we[p]) st_d.word[idx[p]] = wd[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int p = 0; p < 2; p++) rd[p] = st_q.word[idx[p]];
    end

    // R10
    msg_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && we[1]) |=> (st_q.word[$past(idx[1])] == $past(wd[1])));

    // R7
    msg_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && we[0] && !(we[1] && idx[1] == idx[0]))
        |=> (st_q.word[$past(idx[0])] == $past(wd[0])));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int N_MSG    = 64,
    parameter int MSG_BASE = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic              p0_we,
    input  logic [31:0]       p0_wdata,
    output logic [31:0]       p0_rdata,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic              p1_we,
    input  logic [31:0]       p1_wdata,
    output logic [31:0]       p1_rdata,
    output logic              irq0_o,
    output logic              irq1_o
);
    localparam int IDX_W      = $clog2(N_MSG);
    localparam int MSG_BASE_W = MSG_BASE / 4;

    logic [1:0][ADDR_W-1:0] addr_a;
    logic [1:0]             we_a;
    logic [1:0][DATA_W-1:0] wd_a;
    logic [1:0][DATA_W-1:0] rdata_a;

    assign addr_a = {p1_addr, p0_addr};
    assign we_a   = {p1_we, p0_we};
    assign wd_a   = {p1_wdata, p0_wdata};
    assign p0_rdata = rdata_a[0];
    assign p1_rdata = rdata_a[1];

    reg_sel_e [1:0]          sel;
    logic                    soft_rst;
    logic [1:0][HALF-1:0]    set_v, clr_v, stat_v, mask_v;
    logic [1:0][1:0]         mask_we;
    logic [1:0][1:0][HALF-1:0] mask_d;
    logic [1:0]              irq_v;
    logic [1:0]              msg_we;
    logic [1:0][IDX_W-1:0]   msg_idx;
    logic [1:0][DATA_W-1:0]  msg_rd;

    always_comb begin
        soft_rst = 1'b0;
        set_v    = '0;
        clr_v    = '0;
        mask_we  = '0;
        mask_d   = '0;
        msg_we   = '0;
        msg_idx  = '0;
        for (int p = 0; p < 2; p++) begin
            if (addr_a[p][1:0] != 2'b00)
                sel[p] = SEL_NONE;
            else
                sel[p] = decode_word(int'(addr_a[p][ADDR_W-1:2]), MSG_BASE_W, N_MSG);
            msg_idx[p]    = IDX_W'(int'(addr_a[p][ADDR_W-1:2]) - MSG_BASE_W);
            mask_d[0][p]  = wd_a[p][DATA_W-1:HALF];
            mask_d[1][p]  = wd_a[p][HALF-1:0];
            if (we_a[p]) begin
                case (sel[p])
                    SEL_CTRL:  soft_rst = soft_rst | wd_a[p][0];
                    SEL_GEN0:  set_v[0] = set_v[0] | wd_a[p][DATA_W-1:HALF];
                    SEL_CLR0:  clr_v[0] = clr_v[0] | wd_a[p][DATA_W-1:HALF];
                    SEL_MASK0: mask_we[0][p] = 1'b1;
                    SEL_GEN1:  set_v[1] = set_v[1] | wd_a[p][HALF-1:0];
                    SEL_CLR1:  clr_v[1] = clr_v[1] | wd_a[p][HALF-1:0];
                    SEL_MASK1: mask_we[1][p] = 1'b1;
                    SEL_MSG:   msg_we[p] = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        mbx_irq_bank #(.SRC_N(HALF)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .set_vec  (set_v[b]),
            .clr_vec  (clr_v[b]),
            .mask_we  (mask_we[b]),
            .mask_d   (mask_d[b]),
            .stat_o   (stat_v[b]),
            .mask_o   (mask_v[b]),
            .irq_o    (irq_v[b])
        );
    end

    mbx_msg_file #(.N_MSG(N_MSG), .DATA_W(DATA_W)) u_msg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .we       (msg_we),
        .idx      (msg_idx),
        .wd       (wd_a),
        .rd       (msg_rd)
    );

    assign irq0_o = irq_v[0];
    assign irq1_o = irq_v[1];

    always_comb begin
        for (int p = 0; p < 2; p++) begin
            case (sel[p])
                SEL_MASK0: rdata_a[p] = {mask_v[0], {HALF{1'b0}}};
                SEL_STAT0: rdata_a[p] = {stat_v[0], {HALF{1'b0}}};
                SEL_MASK1: rdata_a[p] = {{HALF{1'b0}}, mask_v[1]};
                SEL_STAT1: rdata_a[p] = {{HALF{1'b0}}, stat_v[1]};
                SEL_MSG:   rdata_a[p] = msg_rd[p];
                default:   rdata_a[p] = '0;
            endcase
        end
    end
endmodule

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  p0_addr = '0, p1_addr = '0;
    logic        p0_we = 1'b0, p1_we = 1'b0;
    logic [31:0] p0_wdata = '0, p1_wdata = '0;
    logic [31:0] p0_rdata, p1_rdata;
    logic        irq0_o, irq1_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ipc_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .p0_addr(p0_addr), .p0_we(p0_we), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_addr(p1_addr), .p1_we(p1_we), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
        .irq0_o(irq0_o), .irq1_o(irq1_o)
    );

    // reference model
    localparam logic [31:0] HI = 32'hFFFF_0000;
    localparam logic [31:0] LO = 32'h0000_FFFF;
    logic [31:0] m_stat = '0;
    logic [31:0] m_mask = '0;
    logic [31:0] m_msg [64];

    function automatic logic [31:0] exp_read(logic [8:0] a);
        int w = int'(a[8:2]);
        if (a[1:0] != 2'b00) return 32'h0;
        case (w)
            4:  return m_mask & HI;
            5:  return m_stat & HI;
            10: return m_mask & LO;
            11: return m_stat & LO;
            default: return (w >= 64) ? m_msg[w-64] : 32'h0;
        endcase
    endfunction

    task automatic model_port(logic we, logic [8:0] a, logic [31:0] d,
                              inout logic [31:0] set, inout logic [31:0] clr);
        int w = int'(a[8:2]);
        if (!we || a[1:0] != 2'b00) return;
        case (w)
            2:  set |= d & HI;
            3:  clr |= d & HI;
            4:  m_mask = (m_mask & LO) | (d & HI);
            8:  set |= d & LO;
            9:  clr |= d & LO;
            10: m_mask = (m_mask & HI) | (d & LO);
            default: if (w >= 64) m_msg[w-64] = d;
        endcase
    endtask

    task automatic model_step(logic we0, logic [8:0] a0, logic [31:0] d0,
                              logic we1, logic [8:0] a1, logic [31:0] d1);
        logic [31:0] set = '0, clr = '0;
        bit srst = (we0 && a0 == 9'h000 && d0[0]) || (we1 && a1 == 9'h000 && d1[0]);
        if (srst) begin
            m_stat = '0; m_mask = '0;
            for (int i = 0; i < 64; i++) m_msg[i] = '0;
        end else begin
            model_port(we0, a0, d0, set, clr);
            model_port(we1, a1, d1, set, clr);
            m_stat = (m_stat & ~clr) | set;
        end
    endtask

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic check_irq(string tag);
        check32({tag, " irq0"}, {31'b0, irq0_o}, {31'b0, |(m_stat & ~m_mask & HI)});
        check32({tag, " irq1"}, {31'b0, irq1_o}, {31'b0, |(m_stat & ~m_mask & LO)});
    endtask

    task automatic cycle(logic we0, logic [8:0] a0, logic [31:0] d0,
                         logic we1, logic [8:0] a1, logic [31:0] d1);
        @(negedge clk);
        p0_we = we0; p0_addr = a0; p0_wdata = d0;
        p1_we = we1; p1_addr = a1; p1_wdata = d1;
        @(posedge clk);
        #1;
        model_step(we0, a0, d0, we1, a1, d1);
        p0_we = 1'b0; p1_we = 1'b0;
    endtask

    task automatic wr0(logic [8:0] a, logic [31:0] d);
        cycle(1'b1, a, d, 1'b0, 9'h0, 32'h0);
    endtask

    task automatic wr1(logic [8:0] a, logic [31:0] d);
        cycle(1'b0, 9'h0, 32'h0, 1'b1, a, d);
    endtask

    task automatic rd(int port, logic [8:0] a, string tag);
        @(negedge clk);
        p0_we = 1'b0; p1_we = 1'b0;
        if (port == 0) p0_addr = a; else p1_addr = a;
        #1;
        check32(tag, (port == 0) ? p0_rdata : p1_rdata, exp_read(a));
    endtask

    function automatic logic [8:0] pick_addr();
        case ($urandom % 14)
            0:  return 9'h000;
            1:  return 9'h008;
            2:  return 9'h00C;
            3:  return 9'h010;
            4:  return 9'h014;
            5:  return 9'h020;
            6:  return 9'h024;
            7:  return 9'h028;
            8:  return 9'h02C;
            9:  return 9'h004 + 9'($urandom % 2) * 9'h02C;
            10: return 9'h101 + 9'($urandom % 3);
            default: return 9'h100 + 9'(4 * ($urandom % 64));
        endcase
    endfunction

    function automatic logic [31:0] pick_data(logic [8:0] a);
        logic [31:0] d = $urandom;
        if (a == 9'h000) d[0] = (($urandom % 16) == 0);
        return d;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) m_msg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(0, 9'h014, "R1 stat0");
        rd(1, 9'h02C, "R1 stat1");
        rd(0, 9'h010, "R1 mask0");
        rd(1, 9'h028, "R1 mask1");
        rd(0, 9'h100, "R1 msg0");
        rd(1, 9'h1FC, "R1 msg63");
        check_irq("R1");

        // R2 generate toward side 0 from port 1, low half ignored
        wr1(9'h008, 32'h0005_FFFF);
        rd(0, 9'h014, "R2 stat0 after gen0");
        rd(0, 9'h02C, "R2 stat1 untouched");
        check_irq("R2 gen0");
        // R2 generate toward side 1 from port 0, high half ignored
        wr0(9'h020, 32'hFFFF_0003);
        rd(1, 9'h02C, "R2 stat1 after gen1");
        check_irq("R2 gen1");

        // R5 mask readback of own half only
        wr0(9'h010, 32'hFFFF_FFFF);
        rd(0, 9'h010, "R5 mask0 half");
        // R4 masked source latches but does not interrupt
        check_irq("R4 masked");
        wr1(9'h008, 32'h0010_0000);
        rd(0, 9'h014, "R4 masked latch");
        check_irq("R4 masked gen");

        // R3 selective clear
        wr0(9'h00C, 32'h0001_0000);
        rd(0, 9'h014, "R3 w1c");

        // R6 set beats clear on bit 18; bit 20 cleared while 22 set
        cycle(1'b1, 9'h00C, 32'h0014_0000, 1'b1, 9'h008, 32'h0044_0000);
        rd(0, 9'h014, "R6 set wins");

        // R4 unmask -> irq0 rises
        wr1(9'h010, 32'h0);
        check_irq("R4 unmasked");

        // R3 clear all of bank 1
        wr1(9'h024, 32'h0000_FFFF);
        rd(1, 9'h02C, "R3 clear all bank1");
        check_irq("R3 bank1 empty");

        // R7 messages across ports, no irq side effect
        cycle(1'b1, 9'h114, 32'hCAFE_0005, 1'b1, 9'h1FC, 32'h1234_5678);
        rd(1, 9'h114, "R7 msg5 cross read");
        rd(0, 9'h1FC, "R7 msg63 cross read");
        rd(0, 9'h014, "R7 stat0 unchanged");
        check_irq("R7");

        // R10 collisions keep port 1
        cycle(1'b1, 9'h11C, 32'hAAAA_AAAA, 1'b1, 9'h11C, 32'h5555_5555);
        rd(0, 9'h11C, "R10 msg collision");
        cycle(1'b1, 9'h028, 32'h0000_00F0, 1'b1, 9'h028, 32'h0000_0F00);
        rd(0, 9'h028, "R10 mask collision");

        // R9 unmapped / misaligned / write-only reads
        wr0(9'h004, 32'hFFFF_FFFF);
        wr1(9'h030, 32'hFFFF_FFFF);
        wr0(9'h016, 32'hFFFF_FFFF);
        rd(0, 9'h004, "R9 unmapped read");
        rd(1, 9'h101, "R9 misaligned read");
        rd(0, 9'h008, "R9 gen reads zero");
        rd(1, 9'h024, "R9 clr reads zero");
        rd(0, 9'h014, "R9 stat0 unchanged");
        rd(1, 9'h010, "R9 mask0 unchanged");
        check_irq("R9");

        // R8 software reset overrides a simultaneous message write
        cycle(1'b1, 9'h100, 32'hDEAD_BEEF, 1'b1, 9'h000, 32'h0000_0001);
        rd(0, 9'h100, "R8 msg0 zeroed");
        rd(1, 9'h114, "R8 msg5 zeroed");
        rd(0, 9'h014, "R8 stat0 zeroed");
        rd(1, 9'h028, "R8 mask1 zeroed");
        rd(0, 9'h000, "R8 ctrl reads zero");
        check_irq("R8");

        // random traffic against the model (R2 R3 R4 R5 R6 R7 R8 R9 R10)
        for (int n = 0; n < 600; n++) begin
            logic [8:0] a0 = pick_addr();
            logic [8:0] a1 = pick_addr();
            cycle(1'($urandom % 2), a0, pick_data(a0), 1'($urandom % 2), a1, pick_data(a1));
            check_irq("rand R4");
            rd(0, pick_addr(), "rand R2/R3/R7 port0");
            rd(1, pick_addr(), "rand R5/R9/R10 port1");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule